// File: doc/BRIEF.md
# Interleaved Bitmap Raster Generator

This block turns a shared byte memory into a raster colour stream. The memory holds a one-bit-per-pixel picture of 256 × 192 dots, followed at offset 0x1800 by one colour byte for each 8 × 8 cell. For every eight-pixel group the block computes a picture address in a third/character-row interleaved order and a cell attribute address. It reads both bytes through a synchronous read port one group ahead of display, serialises the pixels and emits a 4-bit colour index with sync and blanking strobes.

Outside the picture the block shows a 3-bit border colour taken from a register input. A frame counter drives a periodic swap of foreground and background in cells whose flash bit is set. The line and frame geometry, the sync and blank windows and the flash period are parameters. The defaults give 448 pixel clocks per line (224 CPU cycles at two pixels per cycle) and 312 lines, which is 69,888 CPU cycles per frame.

Top module: `ilv_video_gen`

## Requirements
- R1: While `rstN` is low, `colorOut`, `hSync`, `vSync` and `blank` are all 0.
- R2: An internal position (x, y) runs through 0..H_TOTAL-1 and 0..V_TOTAL-1, with x incrementing every clock. The first position after reset release is x = H_TOTAL-8 on line V_TOTAL-1, and the frame count becomes 0 on entering (0,0). The outputs for a position appear on the registered outputs one clock later.
- R3: The picture byte for group g of line y is read at address {y[7:6], y[2:0], y[5:3], g[4:0]}, in 13 bits.
- R4: The attribute byte for that group is read at 0x1800 + (y>>3)*32 + g. No read ever addresses 0x1B00 or above.
- R5: Inside the picture (x < 256, y < 192), the pixel is bit 7-(x mod 8) of the picture byte, so bit 7 is leftmost. A 1 selects the foreground colour and a 0 selects the background colour.
- R6: The attribute byte fields are: bit 7 flash, bit 6 bright, bits 5..3 background, bits 2..0 foreground.
- R7: The flash phase is bit FLASH_LOG2 of the frame count, so it toggles every 2^FLASH_LOG2 frames (16 by default). When both the cell's flash bit and the phase are 1, foreground and background swap. The phase changes only on entering (0,0).
- R8: Inside the picture, `colorOut` = {bright, hue}, where hue is the selected 3-bit colour. When hue is 0, the bright bit is forced to 0, so black has one code only.
- R9: Outside the picture and outside blanking, `colorOut` = {0, `borderColor`}, using the value sampled at the same clock edge.
- R10: `blank` is 1 when x is in [H_BLANK_START, H_BLANK_END) or y is in [V_BLANK_START, V_BLANK_END). While `blank` is 1, `colorOut` is 0.
- R11: `hSync` is 1 when x is in [H_SYNC_START, H_SYNC_END), and `vSync` is 1 when y is in [V_SYNC_START, V_SYNC_END). Either sync implies `blank`.
- R12: For the group displayed next, the picture byte is requested at group phase 0 and the attribute byte at phase 1. Here the phase is x mod 8, and the next group is group x/8+1 of the same line, or group 0 of the following line when x ≥ H_TOTAL-8. `memRd` is 1 only on those phases, and only when that group lies inside the picture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| borderColor | input | 3 | Border colour register value |
| memData | input | 8 | Read data, valid one clock after the request |
| memAddr | output | 13 | Byte offset from the bitmap base |
| memRd | output | 1 | Read request |
| colorOut | output | 4 | {bright, hue[2:0]} colour index |
| hSync | output | 1 | Line sync |
| vSync | output | 1 | Frame sync |
| blank | output | 1 | Blanking |

## Verification
Two functions can fall in the same cycle. The first is the frame-count step that flips the flash phase, which coincides with display of group 0 on line 0, after its bytes were fetched during the previous line's tail. The second is a border register change landing on the first pixel after the picture ends. The bench shrinks the frame and flash period so that several phase flips occur in a short run, and it rotates the border colour every 37 clocks so that changes hit the picture edges. A behavioural model derives every expected colour, sync and read address from position and memory content and is compared on every clock.

// File: rtl/ilv_vid_pkg.sv
package ilv_vid_pkg;
  localparam int ADDR_W = 13;
  localparam logic [ADDR_W-1:0] ATTR_BASE = 13'h1800;
  localparam logic [ADDR_W-1:0] ATTR_END  = 13'h1B00;

  typedef struct packed {
    logic loadBitmap;
    logic loadAttr;
    logic loadShift;
    logic active;
    logic blank;
    logic hSync;
    logic vSync;
    logic flashPhase;
  } vidStrobe_t;
endpackage

// File: rtl/ilv_vid_ctrl.sv
module ilv_vid_ctrl
  import ilv_vid_pkg::*;
#(
  parameter int H_TOTAL       = 448,
  parameter int V_TOTAL       = 312,
  parameter int H_BLANK_START = 320,
  parameter int H_BLANK_END   = 384,
  parameter int H_SYNC_START  = 336,
  parameter int H_SYNC_END    = 368,
  parameter int V_BLANK_START = 248,
  parameter int V_BLANK_END   = 256,
  parameter int V_SYNC_START  = 248,
  parameter int V_SYNC_END    = 252,
  parameter int FLASH_LOG2    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output vidStrobe_t        strobe
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam int GW = HW - 3;
  localparam logic [HW-1:0] H_LAST    = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_AHEAD   = HW'(H_TOTAL - 8);
  localparam logic [HW-1:0] H_ACT     = HW'(256);
  localparam logic [HW-1:0] HB_START  = HW'(H_BLANK_START);
  localparam logic [HW-1:0] HB_END    = HW'(H_BLANK_END);
  localparam logic [HW-1:0] HS_START  = HW'(H_SYNC_START);
  localparam logic [HW-1:0] HS_END    = HW'(H_SYNC_END);
  localparam logic [VW-1:0] V_LAST    = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_ACT     = VW'(192);
  localparam logic [VW-1:0] VB_START  = VW'(V_BLANK_START);
  localparam logic [VW-1:0] VB_END    = VW'(V_BLANK_END);
  localparam logic [VW-1:0] VS_START  = VW'(V_SYNC_START);
  localparam logic [VW-1:0] VS_END    = VW'(V_SYNC_END);
  localparam logic [GW-1:0] G_ACT     = GW'(32);

  logic [HW-1:0]       hCnt;
  logic [VW-1:0]       vCnt;
  logic [FLASH_LOG2:0] frameCnt;
  logic                lineEnd, frameEnd;

  assign lineEnd  = (hCnt == H_LAST);
  assign frameEnd = lineEnd && (vCnt == V_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt     <= H_AHEAD;
      vCnt     <= V_LAST;
      frameCnt <= '1;
    end else begin
      hCnt <= lineEnd ? '0 : hCnt + 1'b1;
      if (lineEnd) vCnt <= (vCnt == V_LAST) ? '0 : vCnt + 1'b1;
      if (frameEnd) frameCnt <= frameCnt + 1'b1;
    end
  end

  // Look-ahead fetch target: the group that is shown after the current one
  logic                lookAhead, fetchValid;
  logic [VW-1:0]       fetchY;
  logic [GW-1:0]       fetchG;
  logic [2:0]          phase;
  logic [ADDR_W-1:0]   pixAddr, attrAddr;

  always_comb begin
    lookAhead  = (hCnt >= H_AHEAD);
    fetchY     = lookAhead ? ((vCnt == V_LAST) ? '0 : vCnt + 1'b1) : vCnt;
    fetchG     = lookAhead ? '0 : hCnt[HW-1:3] + 1'b1;
    fetchValid = (fetchY < V_ACT) && (fetchG < G_ACT);
    phase      = hCnt[2:0];
    pixAddr    = {fetchY[7:6], fetchY[2:0], fetchY[5:3], fetchG[4:0]};
    attrAddr   = ATTR_BASE + ADDR_W'({fetchY[7:3], fetchG[4:0]});
    memRd      = fetchValid && (phase == 3'd0 || phase == 3'd1);
    memAddr    = !memRd ? '0 : (phase[0] ? attrAddr : pixAddr);
  end

  always_comb begin
    strobe.loadBitmap = fetchValid && (phase == 3'd1);
    strobe.loadAttr   = fetchValid && (phase == 3'd2);
    strobe.loadShift  = (phase == 3'd7);
    strobe.active     = (hCnt < H_ACT) && (vCnt < V_ACT);
    strobe.blank      = (hCnt >= HB_START && hCnt < HB_END) ||
                        (vCnt >= VB_START && vCnt < VB_END);
    strobe.hSync      = (hCnt >= HS_START) && (hCnt < HS_END);
    strobe.vSync      = (vCnt >= VS_START) && (vCnt < VS_END);
    strobe.flashPhase = frameCnt[FLASH_LOG2];
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (hCnt <= H_LAST) && (vCnt <= V_LAST)); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (hCnt == '0 && vCnt == '0 && $past(rstN)) |-> $past(frameEnd)); // R2
  AST_ATTR_AFTER_PIX: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && memAddr < ATTR_BASE) |=> (memRd && memAddr >= ATTR_BASE)); // R12
  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memAddr < ATTR_END)); // R4
  AST_FLASH_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(frameCnt) |-> (hCnt == '0 && vCnt == '0)); // R7
endmodule

// File: rtl/ilv_vid_datapath.sv
module ilv_vid_datapath
  import ilv_vid_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  vidStrobe_t strobe,
  input  logic [7:0] memData,
  input  logic [2:0] borderColor,
  output logic [3:0] colorOut,
  output logic       hSync,
  output logic       vSync,
  output logic       blank
);
  logic [7:0] bitmapNext, attrNext, shiftReg, attrCur;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitmapNext <= '0;
      attrNext   <= '0;
      shiftReg   <= '0;
      attrCur    <= '0;
    end else begin
      if (strobe.loadBitmap) bitmapNext <= memData;
      if (strobe.loadAttr)   attrNext   <= memData;
      if (strobe.loadShift) begin
        shiftReg <= bitmapNext;
        attrCur  <= attrNext;
      end else begin
        shiftReg <= {shiftReg[6:0], 1'b0};
      end
    end
  end

  logic       swap, useInk, lit;
  logic [2:0] hue;
  logic [3:0] nextColor;

  always_comb begin
    swap      = attrCur[7] & strobe.flashPhase;
    useInk    = shiftReg[7] ^ swap;
    hue       = useInk ? attrCur[2:0] : attrCur[5:3];
    lit       = attrCur[6] && (hue != 3'd0);
    if (strobe.blank)       nextColor = 4'd0;
    else if (strobe.active) nextColor = {lit, hue};
    else                    nextColor = {1'b0, borderColor};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colorOut <= '0;
      hSync    <= 1'b0;
      vSync    <= 1'b0;
      blank    <= 1'b0;
    end else begin
      colorOut <= nextColor;
      hSync    <= strobe.hSync;
      vSync    <= strobe.vSync;
      blank    <= strobe.blank;
    end
  end

  AST_BLACK_NO_BRIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (colorOut[2:0] == 3'd0) |-> !colorOut[3]); // R8
  AST_SYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (hSync || vSync) |-> blank); // R11
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rstN)
    blank |-> (colorOut == 4'd0)); // R10
endmodule

// File: rtl/ilv_video_gen.sv
module ilv_video_gen
  import ilv_vid_pkg::*;
#(
  parameter int H_TOTAL       = 448,
  parameter int V_TOTAL       = 312,
  parameter int H_BLANK_START = 320,
  parameter int H_BLANK_END   = 384,
  parameter int H_SYNC_START  = 336,
  parameter int H_SYNC_END    = 368,
  parameter int V_BLANK_START = 248,
  parameter int V_BLANK_END   = 256,
  parameter int V_SYNC_START  = 248,
  parameter int V_SYNC_END    = 252,
  parameter int FLASH_LOG2    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  borderColor,
  input  logic [7:0]  memData,
  output logic [12:0] memAddr,
  output logic        memRd,
  output logic [3:0]  colorOut,
  output logic        hSync,
  output logic        vSync,
  output logic        blank
);
  vidStrobe_t strobe;

  ilv_vid_ctrl #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
    .H_BLANK_START(H_BLANK_START), .H_BLANK_END(H_BLANK_END),
    .H_SYNC_START(H_SYNC_START), .H_SYNC_END(H_SYNC_END),
    .V_BLANK_START(V_BLANK_START), .V_BLANK_END(V_BLANK_END),
    .V_SYNC_START(V_SYNC_START), .V_SYNC_END(V_SYNC_END),
    .FLASH_LOG2(FLASH_LOG2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .strobe(strobe)
  );

  ilv_vid_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memData(memData),
    .borderColor(borderColor), .colorOut(colorOut),
    .hSync(hSync), .vSync(vSync), .blank(blank)
  );
endmodule

// File: tb/ilv_video_gen_tb.sv
module ilv_video_gen_tb;
  localparam int HT = 264, VT = 196;
  localparam int HBS = 258, HBE = 262, HSS = 259, HSE = 261;
  localparam int VBS = 193, VBE = 195, VSS = 193, VSE = 194;
  localparam int FL = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  borderColor = 3'd0;
  logic [7:0]  memData = 8'd0;
  logic [12:0] memAddr;
  logic        memRd;
  logic [3:0]  colorOut;
  logic        hSync, vSync, blank;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ilv_video_gen #(
    .H_TOTAL(HT), .V_TOTAL(VT),
    .H_BLANK_START(HBS), .H_BLANK_END(HBE), .H_SYNC_START(HSS), .H_SYNC_END(HSE),
    .V_BLANK_START(VBS), .V_BLANK_END(VBE), .V_SYNC_START(VSS), .V_SYNC_END(VSE),
    .FLASH_LOG2(FL)
  ) u_dut (
    .clk(clk), .rstN(rstN), .borderColor(borderColor), .memData(memData),
    .memAddr(memAddr), .memRd(memRd), .colorOut(colorOut),
    .hSync(hSync), .vSync(vSync), .blank(blank)
  );

  function automatic logic [7:0] memByte(input int a);
    return 8'((a * 37) ^ ((a >> 3) * 91) ^ 'h5A);
  endfunction

  function automatic int pixOff(input int y, input int g);
    return ((y & 'hC0) << 5) | ((y & 'h07) << 8) | ((y & 'h38) << 2) | g;
  endfunction

  // synchronous read memory
  always @(posedge clk) memData <= memByte(int'(memAddr));

  // behavioural model
  int mx, my, mframe;
  int expColor, expH, expV, expB;
  string colorTag;

  always @(posedge clk) begin
    if (!rstN) begin
      mx = HT - 8; my = VT - 1; mframe = -1;
      expColor = 0; expH = 0; expV = 0; expB = 0; colorTag = "R1";
    end else begin
      expB = ((mx >= HBS && mx < HBE) || (my >= VBS && my < VBE)) ? 1 : 0;
      expH = (mx >= HSS && mx < HSE) ? 1 : 0;
      expV = (my >= VSS && my < VSE) ? 1 : 0;
      if (expB != 0) begin
        expColor = 0; colorTag = "R10";
      end else if (mx < 256 && my < 192) begin
        automatic int bm = memByte(pixOff(my, mx / 8));
        automatic int at = memByte('h1800 + (my / 8) * 32 + mx / 8);
        automatic int px = (bm >> (7 - mx % 8)) & 1;
        automatic int sw = ((at >> 7) & 1) & ((mframe >> FL) & 1);
        automatic int hue = ((px ^ sw) != 0) ? (at & 7) : ((at >> 3) & 7);
        automatic int br = (((at >> 6) & 1) != 0 && hue != 0) ? 1 : 0;
        expColor = br * 8 + hue;
        colorTag = (sw != 0) ? "R7" : "R5 R6 R8";
      end else begin
        expColor = int'(borderColor); colorTag = "R9";
      end
      if (mx == HT - 1) begin
        mx = 0;
        if (my == VT - 1) begin my = 0; mframe = mframe + 1; end
        else my = my + 1;
      end else mx = mx + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at x=%0d y=%0d frame=%0d",
               tag, act, exp, mx, my, mframe);
    end
  endtask

  task automatic checkMem();
    int fy, g, ph, rd;
    if (mx >= HT - 8) begin fy = (my + 1) % VT; g = 0; end
    else begin fy = my; g = mx / 8 + 1; end
    ph = mx % 8;
    rd = (fy < 192 && g < 32 && ph < 2) ? 1 : 0;
    chk("R12", int'(memRd), rd);
    if (rd != 0 && ph == 0) chk("R3", int'(memAddr), pixOff(fy, g));
    if (rd != 0 && ph == 1) chk("R4", int'(memAddr), 'h1800 + (fy / 8) * 32 + g);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(colorOut), 0);
    chk("R1", int'(hSync), 0);
    chk("R1", int'(vSync), 0);
    chk("R1", int'(blank), 0);
    rstN = 1'b1;
    for (int cyc = 0; !(mframe == 3 && my >= 2); cyc++) begin
      @(negedge clk);
      chk(colorTag, int'(colorOut), expColor);
      chk("R2 R11", int'(hSync), expH);
      chk("R11", int'(vSync), expV);
      chk("R10", int'(blank), expB);
      checkMem();
      if (cyc % 37 == 0) borderColor = borderColor + 3'd3;
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 195000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule